// File: doc/BRIEF.md
# Processor Clock, Reset and Ready Generator

This block turns a fast reference clock into the timing signals a processor and its peripherals need. The reference is taken either from an on-chip oscillator input or from an external frequency input, picked by a select pin. The chosen reference is divided by three to form the processor clock, which is high for one reference period and low for two. A further divide-by-two of the processor clock gives a square-wave peripheral clock. The oscillator input is also passed straight out, so that further generators can use it as their external reference.

Besides the clocks, the block conditions two control levels for the processor. An active-low reset request becomes a processor reset that changes only on falling processor clock edges and is held for a minimum number of processor clocks after the request goes away. Two ready requests, each qualified by its own active-low address enable, are merged and synchronized into one ready output. A mode pin selects a two-flop path (rising edge, then falling edge) or a single falling-edge flop. A sync input clears both dividers so that several generators can start in phase.

All state runs on the selected reference clock. Processor clock edges are tracked as one-cycle enables in that domain, so "updated on the falling edge of the processor clock" means updated on the reference edge that also takes the processor clock low. `rst` is a synchronous active-high reset in the selected reference domain.

Top module: `proc_clk_gen`

## Requirements
- R1: The processor clock period is three periods of the selected reference: `use_ext`=0 selects `osc_in`, `use_ext`=1 selects `ext_in`.
- R2: The processor clock is high for exactly one reference period and low for the next two, repeating.
- R3: The peripheral clock toggles on the same reference edge on which the processor clock rises, giving a period of six reference periods with three high and three low.
- R4: `osc_out` follows `osc_in` at all times, whichever source is selected.
- R5: While `rst` is high `cpu_rst` is 1; any processor-clock falling edge that samples `rst_req_n` low leaves `cpu_rst` at 1.
- R6: After `rst_req_n` returns high, `cpu_rst` stays 1 through the first four processor-clock falling edges that sample it high and goes to 0 at the fifth.
- R7: `cpu_rst` changes only on the reference edge on which the processor clock falls.
- R8: A ready request counts only when its enable is low: the merged request is (`rdy_a` and not `rdy_a_en_n`) or (`rdy_b` and not `rdy_b_en_n`).
- R9: With `rdy_two_stage`=0, `cpu_ready` takes the merged request sampled at each processor-clock falling edge.
- R10: With `rdy_two_stage`=1, the merged request is first sampled at a processor-clock rising edge and reaches `cpu_ready` at the following falling edge.
- R11: While `sync_in` is high both clocks are held low; the first reference edge that samples `sync_in` low raises both the processor and the peripheral clock.
- R12: `cpu_ready` changes only on the reference edge on which the processor clock falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_in | input | 1 | On-chip oscillator reference |
| ext_in | input | 1 | External frequency reference |
| use_ext | input | 1 | Source select: 1 picks `ext_in`, 0 picks `osc_in` |
| rst | input | 1 | Synchronous active-high reset, selected reference domain |
| sync_in | input | 1 | Holds and clears both dividers while high |
| rst_req_n | input | 1 | Active-low processor reset request (clean level) |
| rdy_a | input | 1 | Ready request, channel A |
| rdy_a_en_n | input | 1 | Active-low qualifier for channel A |
| rdy_b | input | 1 | Ready request, channel B |
| rdy_b_en_n | input | 1 | Active-low qualifier for channel B |
| rdy_two_stage | input | 1 | 1: two-flop ready path, 0: one-flop ready path |
| osc_out | output | 1 | Buffered copy of `osc_in` |
| cpu_clk | output | 1 | Processor clock, reference divided by three |
| per_clk | output | 1 | Peripheral clock, processor clock divided by two |
| cpu_rst | output | 1 | Synchronized processor reset |
| cpu_ready | output | 1 | Synchronized processor ready |

## Verification
The hardest behaviour to observe from the ports is the half-cycle latency difference between the two ready modes, since both paths settle to the same value after a full processor clock. The stimulus raises a request just after a processor-clock rising edge and reads `cpu_ready` right after the next falling edge, where the one-stage path already shows it and the two-stage path must not. The reset hold is reached the same way: the request is released between reference edges, and each of the following falling edges is counted at the port until the fifth one drops `cpu_rst`.

// File: rtl/proc_clk_pkg.sv
package proc_clk_pkg;

    // Processor clock edge enables in the reference domain
    typedef struct packed {
        logic rise;   // this reference edge raises the processor clock
        logic fall;   // this reference edge lowers the processor clock
    } phase_t;

    typedef enum logic {
        RDY_ONE_STAGE = 1'b0,
        RDY_TWO_STAGE = 1'b1
    } rdy_mode_e;

    // Merge of the two qualified ready requests
    function automatic logic rdy_request(
        input logic req_a,
        input logic en_a_n,
        input logic req_b,
        input logic en_b_n
    );
        return (req_a & ~en_a_n) | (req_b & ~en_b_n);
    endfunction

endpackage

// File: rtl/pcg_src_sel.sv
module pcg_src_sel (
    input  logic osc_in,
    input  logic ext_in,
    input  logic use_ext,
    output logic ref_clk,
    output logic osc_out
);
    // Source choice is expected to change only while the block is held in reset
    assign ref_clk = use_ext ? ext_in : osc_in;
    assign osc_out = osc_in;
endmodule

// File: rtl/pcg_divider.sv
module pcg_divider
    import proc_clk_pkg::*;
#(
    parameter int unsigned DIV_RATIO = 3
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   sync_in,
    output logic   cpu_clk,
    output logic   per_clk,
    output phase_t ph
);
    localparam int unsigned TOP = DIV_RATIO - 1;
    localparam logic [TOP:0] RING_IDLE = {1'b1, {TOP{1'b0}}};

    logic [TOP:0] ring_q;
    logic         per_q;
    logic         hold;

    assign hold = rst | sync_in;

    // One-hot ring: bit 0 is the processor clock, so it leaves a flop glitch-free
    always_ff @(posedge clk) begin
        if (hold) begin
            ring_q <= RING_IDLE;
            per_q  <= 1'b0;
        end else begin
            ring_q <= {ring_q[TOP-1:0], ring_q[TOP]};
            if (ring_q[TOP]) begin
                per_q <= ~per_q;
            end
        end
    end

    assign cpu_clk = ring_q[0];
    assign per_clk = per_q;
    assign ph.rise = ring_q[TOP] & ~hold;
    assign ph.fall = ring_q[0] & ~hold;
endmodule

// File: rtl/pcg_reset_sync.sv
module pcg_reset_sync
    import proc_clk_pkg::*;
#(
    parameter int unsigned RST_HOLD = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  phase_t ph,
    input  logic   req_n,
    output logic   cpu_rst
);
    localparam int unsigned CW = $clog2(RST_HOLD + 1);
    localparam logic [CW-1:0] HOLD_INIT = CW'(RST_HOLD);

    logic [CW-1:0] hold_cnt;
    logic          rst_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cnt <= HOLD_INIT;
            rst_q    <= 1'b1;
        end else if (ph.fall) begin
            if (!req_n) begin
                hold_cnt <= HOLD_INIT;
                rst_q    <= 1'b1;
            end else if (hold_cnt != '0) begin
                hold_cnt <= hold_cnt - 1'b1;
                rst_q    <= 1'b1;
            end else begin
                rst_q    <= 1'b0;
            end
        end
    end

    assign cpu_rst = rst_q;
endmodule

// File: rtl/pcg_ready_sync.sv
module pcg_ready_sync
    import proc_clk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  phase_t    ph,
    input  rdy_mode_e mode,
    input  logic      req_a,
    input  logic      en_a_n,
    input  logic      req_b,
    input  logic      en_b_n,
    output logic      ready
);
    logic merged;
    logic stage_q;
    logic ready_q;

    assign merged = rdy_request(req_a, en_a_n, req_b, en_b_n);

    // First stage, used only by the two-flop path, samples on rising edges
    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= 1'b0;
        end else if (ph.rise) begin
            stage_q <= merged;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q <= 1'b0;
        end else if (ph.fall) begin
            ready_q <= (mode == RDY_TWO_STAGE) ? stage_q : merged;
        end
    end

    assign ready = ready_q;
endmodule

// File: rtl/proc_clk_gen.sv
module proc_clk_gen
    import proc_clk_pkg::*;
#(
    parameter int unsigned DIV_RATIO = 3,
    parameter int unsigned RST_HOLD  = 4
) (
    input  logic osc_in,
    input  logic ext_in,
    input  logic use_ext,
    input  logic rst,
    input  logic sync_in,
    input  logic rst_req_n,
    input  logic rdy_a,
    input  logic rdy_a_en_n,
    input  logic rdy_b,
    input  logic rdy_b_en_n,
    input  logic rdy_two_stage,
    output logic osc_out,
    output logic cpu_clk,
    output logic per_clk,
    output logic cpu_rst,
    output logic cpu_ready
);
    logic   ref_clk;
    phase_t ph;

    pcg_src_sel src_i (
        .osc_in  (osc_in),
        .ext_in  (ext_in),
        .use_ext (use_ext),
        .ref_clk (ref_clk),
        .osc_out (osc_out)
    );

    pcg_divider #(.DIV_RATIO(DIV_RATIO)) div_i (
        .clk     (ref_clk),
        .rst     (rst),
        .sync_in (sync_in),
        .cpu_clk (cpu_clk),
        .per_clk (per_clk),
        .ph      (ph)
    );

    pcg_reset_sync #(.RST_HOLD(RST_HOLD)) rsync_i (
        .clk     (ref_clk),
        .rst     (rst),
        .ph      (ph),
        .req_n   (rst_req_n),
        .cpu_rst (cpu_rst)
    );

    pcg_ready_sync ysync_i (
        .clk    (ref_clk),
        .rst    (rst),
        .ph     (ph),
        .mode   (rdy_mode_e'(rdy_two_stage)),
        .req_a  (rdy_a),
        .en_a_n (rdy_a_en_n),
        .req_b  (rdy_b),
        .en_b_n (rdy_b_en_n),
        .ready  (cpu_ready)
    );
endmodule

// File: rtl/proc_clk_gen_chk.sv
module proc_clk_gen_chk (
    input logic clk,
    input logic rst,
    input logic sync_in,
    input logic rst_req_n,
    input logic cpu_clk,
    input logic per_clk,
    input logic cpu_rst,
    input logic cpu_ready
);
    // R2
    cpu_high_once_chk: assert property (@(posedge clk) disable iff (rst || sync_in)
        cpu_clk |=> !cpu_clk);

    // R2
    cpu_low_twice_chk: assert property (@(posedge clk) disable iff (rst || sync_in)
        (!cpu_clk && !$past(cpu_clk)) |=> cpu_clk);

    // R3
    per_on_rise_chk: assert property (@(posedge clk) disable iff (rst || sync_in)
        (per_clk != $past(per_clk)) |-> (cpu_clk && !$past(cpu_clk)));

    // R7
    rst_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_rst != $past(cpu_rst)) |-> (!cpu_clk && $past(cpu_clk)));

    // R5
    req_low_rst_chk: assert property (@(posedge clk) disable iff (rst)
        (!cpu_clk && $past(cpu_clk) && !$past(rst_req_n)) |-> cpu_rst);

    // R12
    ready_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_ready != $past(cpu_ready)) |-> (!cpu_clk && $past(cpu_clk)));
endmodule

bind proc_clk_gen proc_clk_gen_chk chk_i (
    .clk       (ref_clk),
    .rst       (rst),
    .sync_in   (sync_in),
    .rst_req_n (rst_req_n),
    .cpu_clk   (cpu_clk),
    .per_clk   (per_clk),
    .cpu_rst   (cpu_rst),
    .cpu_ready (cpu_ready)
);

// File: tb/proc_clk_gen_tb_top.sv
`timescale 1ns/1ps
module proc_clk_gen_tb_top;
    logic osc_in = 1'b0;
    logic ext_in = 1'b0;
    logic use_ext = 1'b0;
    logic rst = 1'b1;
    logic sync_in = 1'b0;
    logic rst_req_n = 1'b1;
    logic rdy_a = 1'b0, rdy_a_en_n = 1'b1;
    logic rdy_b = 1'b0, rdy_b_en_n = 1'b1;
    logic rdy_two_stage = 1'b0;
    logic osc_out, cpu_clk, per_clk, cpu_rst, cpu_ready;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 osc_in = ~osc_in;   // 250 MHz
    always #4 ext_in = ~ext_in;   // 125 MHz

    proc_clk_gen dut_i (
        .osc_in        (osc_in),
        .ext_in        (ext_in),
        .use_ext       (use_ext),
        .rst           (rst),
        .sync_in       (sync_in),
        .rst_req_n     (rst_req_n),
        .rdy_a         (rdy_a),
        .rdy_a_en_n    (rdy_a_en_n),
        .rdy_b         (rdy_b),
        .rdy_b_en_n    (rdy_b_en_n),
        .rdy_two_stage (rdy_two_stage),
        .osc_out       (osc_out),
        .cpu_clk       (cpu_clk),
        .per_clk       (per_clk),
        .cpu_rst       (cpu_rst),
        .cpu_ready     (cpu_ready)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic t_reset_state();
        rst = 1'b1;
        repeat (4) @(negedge osc_in);
        check("R5 reset cpu_rst", cpu_rst, 1);
        check("R11 reset cpu_clk low", cpu_clk, 0);
        check("R11 reset per_clk low", per_clk, 0);
        check("R12 reset cpu_ready", cpu_ready, 0);
        rst = 1'b0;
        repeat (30) @(negedge osc_in);
    endtask

    task automatic t_osc_out();
        @(posedge osc_in) #0.5;
        check("R4 osc_out high", osc_out, 1);
        @(negedge osc_in) #0.5;
        check("R4 osc_out low", osc_out, 0);
    endtask

    task automatic t_clock_pattern();
        @(negedge osc_in) sync_in = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge osc_in);
            check("R11 sync cpu_clk held", cpu_clk, 0);
            check("R11 sync per_clk held", per_clk, 0);
        end
        sync_in = 1'b0;
        for (int k = 0; k < 12; k++) begin
            @(negedge osc_in);
            check("R2 cpu_clk pattern", cpu_clk, (k % 3 == 0) ? 1 : 0);
            check("R3 per_clk pattern", per_clk, ((k % 6) < 3) ? 1 : 0);
        end
    endtask

    task automatic t_src_select();
        realtime t0, t1;
        @(negedge osc_in) rst = 1'b1;
        use_ext = 1'b1;
        repeat (3) @(negedge ext_in);
        rst = 1'b0;
        @(posedge cpu_clk) t0 = $realtime;
        @(posedge cpu_clk) t1 = $realtime;
        check("R1 external period ns", int'(t1 - t0), 24);
        @(negedge ext_in) rst = 1'b1;
        use_ext = 1'b0;
        repeat (4) @(negedge osc_in);
        rst = 1'b0;
        @(posedge cpu_clk) t0 = $realtime;
        @(posedge cpu_clk) t1 = $realtime;
        check("R1 oscillator period ns", int'(t1 - t0), 12);
        repeat (30) @(negedge osc_in);
    endtask

    task automatic t_reset_hold();
        @(negedge osc_in) rst_req_n = 1'b0;
        repeat (3) @(negedge cpu_clk);
        #1 check("R5 request low", cpu_rst, 1);
        @(negedge osc_in) rst_req_n = 1'b1;
        for (int i = 1; i <= 4; i++) begin
            @(negedge cpu_clk);
            #1 check("R6 held after release", cpu_rst, 1);
        end
        @(posedge cpu_clk);
        #1 check("R7 no change on rising edge", cpu_rst, 1);
        @(negedge cpu_clk);
        #1 check("R6 release at fifth fall", cpu_rst, 0);
    endtask

    task automatic t_ready_one();
        rdy_two_stage = 1'b0;
        repeat (2) @(negedge cpu_clk);
        #1 check("R9 idle ready", cpu_ready, 0);
        rdy_a = 1'b1; rdy_a_en_n = 1'b0;
        @(posedge cpu_clk);
        #1 check("R12 no change on rising edge", cpu_ready, 0);
        @(negedge cpu_clk);
        #1 check("R9 one-stage capture", cpu_ready, 1);
        rdy_a_en_n = 1'b1;
        repeat (2) @(negedge cpu_clk);
        #1 check("R8 channel A disabled", cpu_ready, 0);
        rdy_b = 1'b1; rdy_b_en_n = 1'b0;
        repeat (2) @(negedge cpu_clk);
        #1 check("R8 channel B enabled", cpu_ready, 1);
        rdy_b_en_n = 1'b1; rdy_a = 1'b0; rdy_a_en_n = 1'b0;
        repeat (2) @(negedge cpu_clk);
        #1 check("R8 enable without request", cpu_ready, 0);
        rdy_a_en_n = 1'b1; rdy_b = 1'b0;
    endtask

    task automatic t_ready_two();
        rdy_two_stage = 1'b1;
        repeat (3) @(negedge cpu_clk);
        #1 check("R10 idle ready", cpu_ready, 0);
        @(posedge cpu_clk);
        #1 rdy_a = 1'b1; rdy_a_en_n = 1'b0;
        @(negedge cpu_clk);
        #1 check("R10 not yet after first fall", cpu_ready, 0);
        @(negedge cpu_clk);
        #1 check("R10 captured after second fall", cpu_ready, 1);
        rdy_a = 1'b0; rdy_a_en_n = 1'b1;
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #400us;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        t_reset_state();
        t_osc_out();
        t_clock_pattern();
        t_src_select();
        t_reset_hold();
        t_ready_one();
        t_ready_two();
        report();
    end
endmodule